// File: doc/BRIEF.md
# Asynchronous-to-Synchronous Modem Data Bridge

This block sits between a free-running asynchronous host serial line and a synchronous modulator that paces its input with a bit-request clock. Start/stop framed bytes from the host are deserialised with 16x oversampling and placed in a small byte FIFO. The modulator's data clock is resynchronised into the system clock. Each of its rising edges releases exactly one outgoing bit. The host bits are never phase-aligned to the modem's bit timing, so the FIFO absorbs both the phase offset and small rate differences.

A transmission opens at the first bit request that finds the FIFO holding data while the block is idle. It starts with an alternating training preamble and then sends the buffered bytes. The transmission closes at a byte boundary where no further byte is waiting. The next burst again opens with a complete preamble. A rate select sets the host-side baud to one of three nominal rates, matching the modulator's configured rate.

Top module: `syncTxBridge`

## Requirements
- R1: The transmit bit and the transmission-active flag change only in the second system-clock cycle after a rising edge of the data clock has passed the two-stage synchroniser. With the data clock held still, both outputs hold their values indefinitely, even when the FIFO has data.
- R2: Each transmission opens with 16 preamble bits of the form 0,1,0,1,…, starting with 0. The active flag rises together with the first preamble bit, at the first request after the FIFO becomes non-empty while idle.
- R3: After the preamble, buffered bytes are sent in arrival order, least significant bit first, one bit per request. Each bit is held until the next request.
- R4: At a byte boundary, a request that finds the FIFO empty ends the transmission. The active flag falls and the transmit bit returns to 0. The next transmission begins with a fresh preamble.
- R5: The host line uses 8 data bits, no parity and one stop bit, and is idle high. Rate select 0 gives 1200, 1 gives 2400, and 2 or 3 give 4800 bit/s. The oversampling tick divisor is BASE_DIV shifted right by 0, 1 or 2.
- R6: Host bit periods up to about 1% away from nominal still deliver every byte intact and in order.
- R7: A frame whose stop bit samples low is discarded. Reception resumes once the line returns high.
- R8: The FIFO holds 16 bytes. The full flag is set when 16 bytes are held, the empty flag is set when none are held, and the two are never set together.
- R9: A byte completed while the FIFO is full is dropped without disturbing the stored bytes. It sets an overflow flag that stays set until reset.
- R10: After reset, the active flag, the transmit bit, the full flag and the overflow flag read 0, and the empty flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRx | input | 1 | Asynchronous host serial line, idle high |
| dataClk | input | 1 | Bit-request clock from the modulator |
| rateSel | input | 2 | Host baud select (0: 1200, 1: 2400, 2/3: 4800) |
| txBit | output | 1 | Bit presented to the modulator |
| txActive | output | 1 | High while a transmission is in progress |
| fifoFull | output | 1 | Byte buffer holds 16 bytes |
| fifoEmpty | output | 1 | Byte buffer holds no bytes |
| overflow | output | 1 | Sticky flag: a byte was dropped because the buffer was full |

## Verification
A corrupt preamble counter shows up within the first 16 requested bits as a broken 0,1 alternation, or as data starting at the wrong position. A wrong bit counter in the data phase shifts every later byte, so the first byte after the preamble already mismatches. A lost or duplicated FIFO pointer update is visible at the end of the burst as a wrong bit count, or as the flags disagreeing with the number of bytes sent while the modem clock is held. Receiver framing faults appear as altered or extra bytes in the next burst compared.

// File: rtl/bridgePkg.sv
package bridgePkg;

  // Per-request commands from the control FSM to the datapath
  typedef struct packed {
    logic drivePre;   // present a preamble bit
    logic preVal;     // value of that preamble bit
    logic loadByte;   // pop FIFO head and present its LSB
    logic shiftBit;   // present next bit of the current byte
    logic goIdle;     // return the line to 0
  } txStrobes_t;

  typedef enum logic [1:0] {TX_IDLE, TX_PRE, TX_BOUND, TX_DATA} txState_t;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI} rxState_t;

endpackage

// File: rtl/bridgeHostRx.sv
module bridgeHostRx #(
  parameter int BASE_DIV = 2604,
  parameter int DATA_W   = 8,
  parameter int OSR      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRx,
  input  logic [1:0]        rateSel,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData
);
  import bridgePkg::*;

  localparam int DIV_W = $clog2(BASE_DIV + 1);
  localparam int OSR_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DIV_W-1:0] divCnt, divNow;
  logic [1:0]       shAmt;
  logic             tick;
  logic             rxS1, rxS2;
  logic [OSR_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [DATA_W-1:0] shReg;
  rxState_t         state;

  assign shAmt  = (rateSel == 2'd0) ? 2'd0 : (rateSel == 2'd1) ? 2'd1 : 2'd2;
  assign divNow = DIV_W'(BASE_DIV) >> shAmt;
  assign tick   = (divCnt >= divNow - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1 <= 1'b1;
      rxS2 <= 1'b1;
    end else begin
      rxS1 <= hostRx;
      rxS2 <= rxS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      tickCnt   <= '0;
      bitCnt    <= '0;
      shReg     <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      case (state)
        RX_IDLE: if (tick && !rxS2) begin
          state   <= RX_START;
          tickCnt <= '0;
        end
        RX_START: if (tick) begin
          if (tickCnt == OSR_W'(OSR / 2 - 1)) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxS2 ? RX_IDLE : RX_DATA;
          end else tickCnt <= tickCnt + OSR_W'(1);
        end
        RX_DATA: if (tick) begin
          if (tickCnt == OSR_W'(OSR - 1)) begin
            tickCnt <= '0;
            shReg   <= {rxS2, shReg[DATA_W-1:1]};
            if (bitCnt == BIT_W'(DATA_W - 1)) state <= RX_STOP;
            else bitCnt <= bitCnt + BIT_W'(1);
          end else tickCnt <= tickCnt + OSR_W'(1);
        end
        RX_STOP: if (tick) begin
          if (tickCnt == OSR_W'(OSR - 1)) begin
            tickCnt <= '0;
            if (rxS2) begin
              byteValid <= 1'b1;
              byteData  <= shReg;
              state     <= RX_IDLE;
            end else state <= RX_WAITHI;
          end else tickCnt <= tickCnt + OSR_W'(1);
        end
        RX_WAITHI: if (rxS2) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dataClk,
  input  logic                   byteValid,
  input  logic [DATA_W-1:0]      byteData,
  input  bridgePkg::txStrobes_t  strobes,
  output logic                   reqPulse,
  output logic                   txBit,
  output logic                   fifoFull,
  output logic                   fifoEmpty,
  output logic                   overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [2:0]        dSync;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic [DATA_W-1:0] shReg;
  logic              push, pop;

  // two-stage synchroniser plus edge register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dSync <= '0;
    else dSync <= {dSync[1:0], dataClk};
  end
  assign reqPulse = dSync[1] & ~dSync[2];

  assign fifoFull  = (fill == CNT_W'(DEPTH));
  assign fifoEmpty = (fill == '0);
  assign push      = byteValid & ~fifoFull;
  assign pop       = strobes.loadByte & ~fifoEmpty;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= byteData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + PTR_W'(1);
      if (push && !pop) fill <= fill + CNT_W'(1);
      else if (pop && !push) fill <= fill - CNT_W'(1);
      if (byteValid && fifoFull) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit <= 1'b0;
      shReg <= '0;
    end else if (strobes.drivePre) begin
      txBit <= strobes.preVal;
    end else if (pop) begin
      txBit <= mem[rdPtr][0];
      shReg <= mem[rdPtr] >> 1;
    end else if (strobes.shiftBit) begin
      txBit <= shReg[0];
      shReg <= shReg >> 1;
    end else if (strobes.goIdle) begin
      txBit <= 1'b0;
    end
  end

endmodule

// File: rtl/bridgeControl.sv
module bridgeControl #(
  parameter int DATA_W  = 8,
  parameter int PRE_LEN = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqPulse,
  input  logic                  fifoEmpty,
  output bridgePkg::txStrobes_t strobes,
  output logic                  txActive
);
  import bridgePkg::*;

  localparam int PRE_W = $clog2(PRE_LEN);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int CW    = (PRE_W > BIT_W) ? PRE_W : BIT_W;

  txState_t state, stateNx;
  logic [CW-1:0] cnt, cntNx;
  logic activeNx;

  always_comb begin
    strobes  = '0;
    stateNx  = state;
    cntNx    = cnt;
    activeNx = txActive;
    if (reqPulse) begin
      case (state)
        TX_IDLE: if (!fifoEmpty) begin
          strobes.drivePre = 1'b1;
          strobes.preVal   = 1'b0;
          stateNx  = TX_PRE;
          cntNx    = CW'(1);
          activeNx = 1'b1;
        end
        TX_PRE: begin
          strobes.drivePre = 1'b1;
          strobes.preVal   = cnt[0];
          if (cnt == CW'(PRE_LEN - 1)) stateNx = TX_BOUND;
          else cntNx = cnt + CW'(1);
        end
        TX_BOUND: if (!fifoEmpty) begin
          strobes.loadByte = 1'b1;
          stateNx = TX_DATA;
          cntNx   = CW'(1);
        end else begin
          strobes.goIdle = 1'b1;
          stateNx  = TX_IDLE;
          activeNx = 1'b0;
        end
        TX_DATA: begin
          strobes.shiftBit = 1'b1;
          if (cnt == CW'(DATA_W - 1)) stateNx = TX_BOUND;
          else cntNx = cnt + CW'(1);
        end
        default: stateNx = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= TX_IDLE;
      cnt      <= '0;
      txActive <= 1'b0;
    end else begin
      state    <= stateNx;
      cnt      <= cntNx;
      txActive <= activeNx;
    end
  end

endmodule

// File: rtl/syncTxBridge.sv
module syncTxBridge #(
  parameter int BASE_DIV   = 2604,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int PRE_LEN    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostRx,
  input  logic       dataClk,
  input  logic [1:0] rateSel,
  output logic       txBit,
  output logic       txActive,
  output logic       fifoFull,
  output logic       fifoEmpty,
  output logic       overflow
);
  import bridgePkg::*;

  logic              byteValid;
  logic [DATA_W-1:0] byteData;
  logic              reqPulse;
  txStrobes_t        strobes;

  bridgeHostRx #(.BASE_DIV(BASE_DIV), .DATA_W(DATA_W), .OSR(16)) rx_i (
    .clk(clk), .rstN(rstN), .hostRx(hostRx), .rateSel(rateSel),
    .byteValid(byteValid), .byteData(byteData)
  );

  bridgeDatapath #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .dataClk(dataClk), .byteValid(byteValid),
    .byteData(byteData), .strobes(strobes), .reqPulse(reqPulse),
    .txBit(txBit), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .overflow(overflow)
  );

  bridgeControl #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) ctl_i (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .fifoEmpty(fifoEmpty),
    .strobes(strobes), .txActive(txActive)
  );

endmodule

// File: rtl/syncTxBridgeChk.sv
module syncTxBridgeChk (
  input logic clk,
  input logic rstN,
  input logic reqPulse,
  input logic byteValid,
  input logic txBit,
  input logic txActive,
  input logic fifoFull,
  input logic fifoEmpty,
  input logic overflow
);

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txBit) |-> $past(reqPulse));

  // R1
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txActive) |-> $past(reqPulse));

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> !txBit);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && fifoFull) |=> overflow);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

endmodule

bind syncTxBridge syncTxBridgeChk chk_i (
  .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .byteValid(byteValid),
  .txBit(txBit), .txActive(txActive), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty), .overflow(overflow)
);

// File: tb/syncTxBridge_tb_top.sv
module syncTxBridge_tb_top;

  localparam int BASE_DIV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRx = 1'b1;
  logic dataClk = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic txBit, txActive, fifoFull, fifoEmpty, overflow;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  bit dclkRun = 1'b0;
  int dHalf = 80;

  bit gotBits[$];
  logic [7:0] sent[$];
  int txDone = 0;
  bit prevAct = 1'b0;

  syncTxBridge #(.BASE_DIV(BASE_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .hostRx(hostRx), .dataClk(dataClk),
    .rateSel(rateSel), .txBit(txBit), .txActive(txActive),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .overflow(overflow)
  );

  always #10 clk = ~clk;

  // modulator bit-request clock
  initial begin
    forever begin
      if (dclkRun) begin
        dataClk = 1'b1;
        repeat (dHalf) @(negedge clk);
        dataClk = 1'b0;
        repeat (dHalf) @(negedge clk);
      end else @(negedge clk);
    end
  end

  // collect bits mid-period, at the falling edge of the request clock
  always @(negedge dataClk) begin
    if (txActive) gotBits.push_back(txBit);
    if (prevAct && !txActive) txDone++;
    prevAct = txActive;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bitCyc(input int rate);
    return 16 * (BASE_DIV >> ((rate == 0) ? 0 : (rate == 1) ? 1 : 2));
  endfunction

  task automatic sendFrame(input logic [7:0] b, input int bc, input bit goodStop);
    @(negedge clk);
    hostRx = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hostRx = b[i];
      repeat (bc) @(negedge clk);
    end
    hostRx = goodStop;
    repeat (bc) @(negedge clk);
    hostRx = 1'b1;
    if (!goodStop) repeat (2 * bc) @(negedge clk);
  endtask

  task automatic hostBytes(input int n, input int bc);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      sent.push_back(b);
      sendFrame(b, bc, 1'b1);
    end
  endtask

  task automatic setRate(input int rate);
    rateSel = 2'(rate);
    dHalf = bitCyc(rate) * 10 / 16;
  endtask

  // compare one finished transmission with the expected stream
  task automatic checkStream(input string tag);
    bit exp[$];
    int firstBad;
    for (int k = 0; k < 16; k++) exp.push_back(bit'(k & 1));
    foreach (sent[j]) for (int i = 0; i < 8; i++) exp.push_back(sent[j][i]);
    // R4: exact bit count, then the transmission ends
    chk(gotBits.size() == exp.size(), {"R4 length ", tag}, gotBits.size(), exp.size());
    firstBad = -1;
    for (int k = 0; k < 16 && k < gotBits.size(); k++)
      if (gotBits[k] != exp[k] && firstBad < 0) firstBad = k;
    // R2: alternating preamble starting with 0
    chk(firstBad < 0, {"R2 preamble ", tag}, firstBad, -1);
    firstBad = -1;
    for (int k = 16; k < exp.size() && k < gotBits.size(); k++)
      if (gotBits[k] != exp[k] && firstBad < 0) firstBad = k;
    // R3: data LSB first in arrival order
    chk(firstBad < 0, {"R3 data ", tag}, firstBad, -1);
    chk(txBit == 1'b0 && txActive == 1'b0, {"R4 idle ", tag}, int'(txBit), 0);
    chk(fifoEmpty == 1'b1, {"R8 empty after ", tag}, int'(fifoEmpty), 1);
  endtask

  task automatic clearRun();
    gotBits.delete();
    sent.delete();
  endtask

  initial begin
    int startDone;
    logic [7:0] bad;
    logic holdBit;
    void'($urandom(32'd24680));
    repeat (10) @(negedge clk);
    // R10 reset state
    chk(txActive == 1'b0, "R10 active", int'(txActive), 0);
    chk(txBit == 1'b0, "R10 txBit", int'(txBit), 0);
    chk(fifoEmpty == 1'b1, "R10 empty", int'(fifoEmpty), 1);
    chk(fifoFull == 1'b0 && overflow == 1'b0, "R10 full/ovf", int'(fifoFull | overflow), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R5 R2 R3 R4: 1200 bit/s burst
    clearRun(); setRate(0); dclkRun = 1'b1;
    startDone = txDone;
    hostBytes(4, bitCyc(0));
    wait (txDone > startDone);
    checkStream("R5 1200");

    // R1 R5: 2400 bit/s burst with the request clock paused mid-transmission
    clearRun(); setRate(1);
    startDone = txDone;
    fork
      hostBytes(6, bitCyc(1));
      begin
        wait (txActive);
        repeat (3) @(negedge dataClk);
        dclkRun = 1'b0;
        @(negedge clk);
        holdBit = txBit;
        repeat (600) @(negedge clk);
        chk(txBit == holdBit && txActive, "R1 hold while paused", int'(txBit), int'(holdBit));
        dclkRun = 1'b1;
      end
    join
    wait (txDone > startDone);
    checkStream("R5 2400 paused");

    // R5: 4800 bit/s burst
    clearRun(); setRate(2);
    startDone = txDone;
    hostBytes(10, bitCyc(2));
    wait (txDone > startDone);
    checkStream("R5 4800");

    // R6: fast host at 2400, slow host at 1200
    clearRun(); setRate(1);
    startDone = txDone;
    hostBytes(8, bitCyc(1) - 1);
    wait (txDone > startDone);
    checkStream("R6 fast host");
    clearRun(); setRate(0);
    startDone = txDone;
    hostBytes(5, bitCyc(0) + 1);
    wait (txDone > startDone);
    checkStream("R6 slow host");

    // R7: bad stop bit frame dropped; R1: no start without a request
    clearRun(); setRate(1); dclkRun = 1'b0;
    repeat (4 * dHalf) @(negedge clk);
    hostBytes(1, bitCyc(1));
    bad = 8'h5A;
    sendFrame(bad, bitCyc(1), 1'b0);
    hostBytes(1, bitCyc(1));
    repeat (200) @(negedge clk);
    chk(txActive == 1'b0 && fifoEmpty == 1'b0, "R1 no start without request", int'(txActive), 0);
    startDone = txDone;
    dclkRun = 1'b1;
    wait (txDone > startDone);
    checkStream("R7 bad stop");

    // R8 R9: fill the FIFO with the request clock stopped, then overflow it
    clearRun(); setRate(2); dclkRun = 1'b0;
    repeat (4 * dHalf) @(negedge clk);
    hostBytes(15, bitCyc(2));
    chk(fifoFull == 1'b0, "R8 not full at 15", int'(fifoFull), 0);
    hostBytes(1, bitCyc(2));
    chk(fifoFull == 1'b1 && overflow == 1'b0, "R8 full at 16", int'(fifoFull), 1);
    sendFrame(8'($urandom), bitCyc(2), 1'b1);
    repeat (10) @(negedge clk);
    chk(overflow == 1'b1, "R9 overflow set", int'(overflow), 1);
    startDone = txDone;
    dclkRun = 1'b1;
    wait (txDone > startDone);
    checkStream("R9 dropped byte");
    chk(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule